// File: doc/BRIEF.md
# Circular Peripheral-to-Memory DMA Channel

This block is one DMA channel that copies items of a chosen size (byte, half-word or word) from a peripheral data register into a memory buffer. The peripheral's request line paces the copying: each item is read from the peripheral over a simple memory-mapped master port and then written to the current buffer slot. Software sets up the channel through a small register window. It writes the peripheral address, the buffer base, the item count and a control word, then sets the enable bit.

In one-shot mode the channel stops by itself after the last item and clears its enable bit. In circular mode it reloads the count and returns to the buffer base after the last item, so capture continues without a gap. Software receives a half-way flag and an end-of-pass flag and can process one half of the buffer while the other half fills. The flags drive a single interrupt line through per-flag enables. Software clears them by writing ones to a separate clear register. While the channel is running, its setup registers are locked.

Register map (cfgAddr): 0 control, 1 peripheral address, 2 buffer base, 3 item count (a read returns the live remaining count), 4 status (read-only), 5 flag clear (reads as 0). Other offsets read as 0.

Top module: `ringDmaChannel`

## Requirements
- R1: Each item is one bus read at the current peripheral address followed by one bus write, at the current buffer address, of the data word captured from that read. During both phases busSize carries the item-size code: control bits 5:4, 0 = byte, 1 = half-word, 2 = word.
- R2: A new item's read starts only after periphReq has been sampled high while the channel waits. Each bus phase holds busReq, busAddr and busWrite steady until busReady is sampled high.
- R3: Reading register 3 returns the live remaining count. It equals the programmed count when the channel is enabled and drops by one after each item's write completes.
- R4: When control bit 2 is set, the buffer address advances by the item size in bytes (1, 2 or 4) after each item. The peripheral address stays fixed unless control bit 3 is set, in which case it advances by the same amount.
- R5: When the last item of a pass completes, status bit 0 (end of pass) is set. In one-shot mode (control bit 1 clear), the channel also clears its enable bit (control bit 0) and issues no further bus access.
- R6: In circular mode (control bit 1 set), finishing a pass reloads the remaining count, moves the buffer address back to the base and the peripheral address back to its programmed value, and keeps serving requests.
- R7: Status bit 1 (half-way) is set in every pass when the number of items moved in that pass reaches floor(N/2), where N is the programmed count and N >= 2.
- R8: irq is high while any status flag is set together with its enable: bit 0 with control bit 6, bit 1 with control bit 7, and bit 2 with control bit 8.
- R9: Writing register 5 clears each status flag whose bit (0, 1 or 2) is written as 1. Bits written as 0 leave their flags unchanged.
- R10: While the channel is enabled or still finishing an item, writes to registers 1, 2 and 3 are ignored. A write to register 0 can then only clear the enable bit and leaves every other control field unchanged.
- R11: If the buffer address or the peripheral address is not a multiple of the item size when a request arrives, the channel sets status bit 2 (error), clears its enable bit and issues no bus access.
- R12: Clearing the enable bit while an item is in flight lets that item's read, write and count update finish. After that no further item starts, even if periphReq stays high.
- R13: Setting the enable bit while the programmed count is 0 has no effect: the enable bit reads back as 0 and no bus access occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Register write strobe for one cycle |
| cfgAddr | input | 3 | Register offset for reads and writes |
| cfgWdata | input | ADDR_W | Register write data |
| cfgRdata | output | ADDR_W | Register read data for cfgAddr (combinational) |
| periphReq | input | 1 | Peripheral request: an item is ready |
| busReq | output | 1 | Master port access request |
| busWrite | output | 1 | 1 = write phase, 0 = read phase |
| busAddr | output | ADDR_W | Byte address of the access |
| busSize | output | 2 | Item-size code of the access |
| busWdata | output | DATA_W | Write data (the captured item) |
| busReady | input | 1 | Slave accepts the current phase |
| busRdata | input | DATA_W | Read data, valid when busReady is high in a read phase |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with ADDR_W = 16, DATA_W = 32 and CNT_W = 6. With a 16-bit address space, the bench's memory image stays small. A six-bit count keeps several circular passes and a full pass restart within a short run. These values reach the wrap back to the base, the repeated half-way flag in the second pass, the peripheral-increment case and the misaligned-address stop, with a stalling slave and a sparse request line applied together. A behavioural model built from integers predicts every bus output, the interrupt and the addressed register value on each clock.

// File: rtl/ringDmaPkg.sv
`timescale 1ns/1ps
package ringDmaPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_UPDATE
  } chanState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capture;   // latch read data
    logic step;      // advance count and addresses
    logic errStop;   // alignment fault, stop channel
  } ctrlStrobe_t;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_PADDR  = 3'd1;
  localparam logic [2:0] OFS_MBASE  = 3'd2;
  localparam logic [2:0] OFS_COUNT  = 3'd3;
  localparam logic [2:0] OFS_STATUS = 3'd4;
  localparam logic [2:0] OFS_CLEAR  = 3'd5;

  localparam int B_EN    = 0;
  localparam int B_CIRC  = 1;
  localparam int B_MINC  = 2;
  localparam int B_PINC  = 3;
  localparam int B_SIZE  = 4;
  localparam int B_TCIE  = 6;
  localparam int B_HTIE  = 7;
  localparam int B_ERRIE = 8;

  localparam int F_TC  = 0;
  localparam int F_HT  = 1;
  localparam int F_ERR = 2;
  localparam int NFLAG = 3;

endpackage

// File: rtl/ringDmaCtrl.sv
`timescale 1ns/1ps
module ringDmaCtrl
  import ringDmaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanEn,
  input  logic        circMode,
  input  logic        misaligned,
  input  logic        lastItem,
  input  logic        periphReq,
  input  logic        busReady,
  output chanState_t  curState,
  output ctrlStrobe_t strobe
);

  chanState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end

  always_comb begin
    nextState = curState;
    strobe    = '0;
    unique case (curState)
      ST_IDLE: begin
        if (chanEn) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (!chanEn) begin
          nextState = ST_IDLE;
        end else if (periphReq) begin
          if (misaligned) begin
            strobe.errStop = 1'b1;
            nextState      = ST_IDLE;
          end else begin
            nextState = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (busReady) begin
          strobe.capture = 1'b1;
          nextState      = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (busReady) nextState = ST_UPDATE;
      end
      ST_UPDATE: begin
        strobe.step = 1'b1;
        if (!chanEn || (lastItem && !circMode)) nextState = ST_IDLE;
        else                                    nextState = ST_WAIT;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ringDmaPath.sv
`timescale 1ns/1ps
module ringDmaPath
  import ringDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [2:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  input  ctrlStrobe_t       strobe,
  input  logic              active,
  input  logic [DATA_W-1:0] busRdata,
  output logic              chanEn,
  output logic              circMode,
  output logic              misaligned,
  output logic              lastItem,
  output logic [ADDR_W-1:0] perAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        itemSize,
  output logic [DATA_W-1:0] dataHold,
  output logic [NFLAG-1:0]  flagVec,
  output logic [NFLAG-1:0]  ieVec
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              memInc, perInc;
  logic [ADDR_W-1:0] perBase, memBase;
  logic [CNT_W-1:0]  progCnt, remaining, movedNow;
  logic [ADDR_W-1:0] itemBytes, alignMask;
  logic              lockCfg, halfHit;
  logic              wrCtrl, wrPaddr, wrMbase, wrCount, wrClear;

  always_comb begin
    unique case (itemSize)
      2'd0:    itemBytes = ADDR_W'(1);
      2'd1:    itemBytes = ADDR_W'(2);
      default: itemBytes = ADDR_W'(4);
    endcase
  end

  assign alignMask  = itemBytes - ADDR_W'(1);
  assign misaligned = |((memAddr | perAddr) & alignMask);
  assign lastItem   = (remaining == CNT_ONE);
  assign lockCfg    = chanEn | active;
  assign movedNow   = progCnt - remaining + CNT_ONE;
  assign halfHit    = strobe.step && (movedNow == (progCnt >> 1));

  assign wrCtrl  = cfgWrite && (cfgAddr == OFS_CTRL);
  assign wrPaddr = cfgWrite && (cfgAddr == OFS_PADDR);
  assign wrMbase = cfgWrite && (cfgAddr == OFS_MBASE);
  assign wrCount = cfgWrite && (cfgAddr == OFS_COUNT);
  assign wrClear = cfgWrite && (cfgAddr == OFS_CLEAR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanEn    <= 1'b0;
      circMode  <= 1'b0;
      memInc    <= 1'b0;
      perInc    <= 1'b0;
      itemSize  <= 2'd0;
      ieVec     <= '0;
      flagVec   <= '0;
      perBase   <= '0;
      memBase   <= '0;
      perAddr   <= '0;
      memAddr   <= '0;
      progCnt   <= '0;
      remaining <= '0;
      dataHold  <= '0;
    end else begin
      if (strobe.capture) dataHold <= busRdata;

      if (wrClear) flagVec <= flagVec & ~cfgWdata[NFLAG-1:0];

      if (wrCtrl) begin
        if (!lockCfg) begin
          circMode       <= cfgWdata[B_CIRC];
          memInc         <= cfgWdata[B_MINC];
          perInc         <= cfgWdata[B_PINC];
          itemSize       <= cfgWdata[B_SIZE +: 2];
          ieVec[F_TC]    <= cfgWdata[B_TCIE];
          ieVec[F_HT]    <= cfgWdata[B_HTIE];
          ieVec[F_ERR]   <= cfgWdata[B_ERRIE];
          if (cfgWdata[B_EN] && (progCnt != '0)) begin
            chanEn    <= 1'b1;
            remaining <= progCnt;
            memAddr   <= memBase;
            perAddr   <= perBase;
          end
        end else if (!cfgWdata[B_EN]) begin
          chanEn <= 1'b0;
        end
      end

      if (wrPaddr && !lockCfg) perBase <= cfgWdata;
      if (wrMbase && !lockCfg) memBase <= cfgWdata;
      if (wrCount && !lockCfg) begin
        progCnt   <= cfgWdata[CNT_W-1:0];
        remaining <= cfgWdata[CNT_W-1:0];
      end

      if (halfHit) flagVec[F_HT] <= 1'b1;

      if (strobe.step) begin
        if (lastItem) begin
          flagVec[F_TC] <= 1'b1;
          if (circMode) begin
            remaining <= progCnt;
            memAddr   <= memBase;
            perAddr   <= perBase;
          end else begin
            remaining <= '0;
            chanEn    <= 1'b0;
          end
        end else begin
          remaining <= remaining - CNT_ONE;
          if (memInc) memAddr <= memAddr + itemBytes;
          if (perInc) perAddr <= perAddr + itemBytes;
        end
      end

      if (strobe.errStop) begin
        flagVec[F_ERR] <= 1'b1;
        chanEn         <= 1'b0;
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    unique case (cfgAddr)
      OFS_CTRL: begin
        cfgRdata[B_EN]         = chanEn;
        cfgRdata[B_CIRC]       = circMode;
        cfgRdata[B_MINC]       = memInc;
        cfgRdata[B_PINC]       = perInc;
        cfgRdata[B_SIZE +: 2]  = itemSize;
        cfgRdata[B_TCIE]       = ieVec[F_TC];
        cfgRdata[B_HTIE]       = ieVec[F_HT];
        cfgRdata[B_ERRIE]      = ieVec[F_ERR];
      end
      OFS_PADDR:  cfgRdata = perBase;
      OFS_MBASE:  cfgRdata = memBase;
      OFS_COUNT:  cfgRdata[CNT_W-1:0] = remaining;
      OFS_STATUS: cfgRdata[NFLAG-1:0] = flagVec;
      default:    cfgRdata = '0;
    endcase
  end

endmodule

// File: rtl/ringDmaChannel.sv
`timescale 1ns/1ps
module ringDmaChannel
  import ringDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [2:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  input  logic              periphReq,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  chanState_t        curState;
  ctrlStrobe_t       strobe;
  logic              chanEn, circMode, misaligned, lastItem;
  logic [ADDR_W-1:0] perAddr, memAddr;
  logic [NFLAG-1:0]  flagVec, ieVec;

  ringDmaCtrl ctrlInst (
    .clk        (clk),
    .rstN       (rstN),
    .chanEn     (chanEn),
    .circMode   (circMode),
    .misaligned (misaligned),
    .lastItem   (lastItem),
    .periphReq  (periphReq),
    .busReady   (busReady),
    .curState   (curState),
    .strobe     (strobe)
  );

  ringDmaPath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) pathInst (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrite   (cfgWrite),
    .cfgAddr    (cfgAddr),
    .cfgWdata   (cfgWdata),
    .cfgRdata   (cfgRdata),
    .strobe     (strobe),
    .active     (curState != ST_IDLE),
    .busRdata   (busRdata),
    .chanEn     (chanEn),
    .circMode   (circMode),
    .misaligned (misaligned),
    .lastItem   (lastItem),
    .perAddr    (perAddr),
    .memAddr    (memAddr),
    .itemSize   (busSize),
    .dataHold   (busWdata),
    .flagVec    (flagVec),
    .ieVec      (ieVec)
  );

  assign busReq   = (curState == ST_READ) || (curState == ST_WRITE);
  assign busWrite = (curState == ST_WRITE);
  assign busAddr  = (curState == ST_READ) ? perAddr : memAddr;
  assign irq      = |(flagVec & ieVec);

endmodule

// File: rtl/ringDmaChannel_chk.sv
`timescale 1ns/1ps
module ringDmaChannel_chk
  import ringDmaPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              periphReq,
  input logic              busReq,
  input logic              busWrite,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input chanState_t        curState,
  input logic              chanEn,
  input logic              tcFlag,
  input logic              errFlag
);

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busAddr) && $stable(busWrite)));

  // R2
  req_paced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite && !$past(busReq)) |-> $past(periphReq));

  // R1
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite && busReady) |=> (busReq && busWrite));

  // R5
  tc_from_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tcFlag) |-> $past(curState == ST_UPDATE));

  // R11
  err_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (!chanEn && !busReq));

  // R12
  disabled_idles_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEn && curState == ST_WAIT) |=> (curState == ST_IDLE));

endmodule

bind ringDmaChannel ringDmaChannel_chk #(.ADDR_W(ADDR_W)) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .periphReq (periphReq),
  .busReq    (busReq),
  .busWrite  (busWrite),
  .busReady  (busReady),
  .busAddr   (busAddr),
  .curState  (curState),
  .chanEn    (chanEn),
  .tcFlag    (flagVec[0]),
  .errFlag   (flagVec[2])
);

// File: tb/ringDmaChannel_test.sv
`timescale 1ns/1ps
module ringDmaChannel_test;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 6;
  localparam logic [DW-1:0] DATA0 = 32'h1000_0000;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWrite;
  logic [2:0]    cfgAddr;
  logic [AW-1:0] cfgWdata;
  logic [AW-1:0] cfgRdata;
  logic          periphReq;
  logic          busReq, busWrite;
  logic [AW-1:0] busAddr;
  logic [1:0]    busSize;
  logic [DW-1:0] busWdata;
  logic          busReady;
  logic [DW-1:0] busRdata;
  logic          irq;

  always #4 clk = ~clk;

  ringDmaChannel #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .periphReq(periphReq),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .irq(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  int rdCnt = 0, wrCnt = 0;
  int reqMode = 0, readyMode = 0;
  logic [AW-1:0] lastRdAddr = '0;
  logic [DW-1:0] memImg [int];

  assign busRdata = DATA0 + 32'h11 * rdCnt;

  // behavioural reference state
  bit mEn, mCirc, mMinc, mPinc, mTcIe, mHtIe, mErrIe, mTc, mHt, mErr;
  int mSize, mProg, mRem, mPh;
  logic [AW-1:0] mPerP, mBase, mMem, mPer;
  logic [DW-1:0] mData;

  function automatic logic [DW-1:0] val(input int r);
    return DATA0 + 32'h11 * r;
  endfunction

  function automatic logic [AW-1:0] ctrlWord(input bit en, circ, minc, pinc,
                                             input int size, input bit tcIe, htIe, errIe);
    logic [AW-1:0] w = '0;
    w[0] = en; w[1] = circ; w[2] = minc; w[3] = pinc;
    w[5:4] = size[1:0]; w[6] = tcIe; w[7] = htIe; w[8] = errIe;
    return w;
  endfunction

  function automatic logic [AW-1:0] mReadReg(input logic [2:0] a);
    case (a)
      3'd0: return ctrlWord(mEn, mCirc, mMinc, mPinc, mSize, mTcIe, mHtIe, mErrIe);
      3'd1: return mPerP;
      3'd2: return mBase;
      3'd3: return AW'(mRem);
      3'd4: return {13'd0, mErr, mHt, mTc};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic modelStep();
    int bytes, nPh;
    bit mis, lockC, last, stepEv, errEv;
    bytes  = (mSize == 0) ? 1 : (mSize == 1) ? 2 : 4;
    mis    = ((mMem % bytes) != 0) || ((mPer % bytes) != 0);
    lockC  = mEn || (mPh != 0);
    last   = (mRem == 1);
    stepEv = 0; errEv = 0;
    nPh    = mPh;
    case (mPh)
      0: if (mEn) nPh = 1;
      1: if (!mEn) nPh = 0;
         else if (periphReq) begin
           if (mis) begin errEv = 1; nPh = 0; end
           else nPh = 2;
         end
      2: if (busReady) begin mData = busRdata; nPh = 3; end
      3: if (busReady) nPh = 4;
      default: begin
        stepEv = 1;
        nPh = (!mEn || (last && !mCirc)) ? 0 : 1;
      end
    endcase
    if (cfgWrite) begin
      case (cfgAddr)
        3'd0: if (!lockC) begin
                mCirc = cfgWdata[1]; mMinc = cfgWdata[2]; mPinc = cfgWdata[3];
                mSize = int'(cfgWdata[5:4]); mTcIe = cfgWdata[6];
                mHtIe = cfgWdata[7]; mErrIe = cfgWdata[8];
                if (cfgWdata[0] && mProg != 0) begin
                  mEn = 1; mRem = mProg; mMem = mBase; mPer = mPerP;
                end
              end else if (!cfgWdata[0]) mEn = 0;
        3'd1: if (!lockC) mPerP = cfgWdata;
        3'd2: if (!lockC) mBase = cfgWdata;
        3'd3: if (!lockC) begin mProg = int'(cfgWdata) % 64; mRem = mProg; end
        3'd5: begin
                if (cfgWdata[0]) mTc = 0;
                if (cfgWdata[1]) mHt = 0;
                if (cfgWdata[2]) mErr = 0;
              end
        default: ;
      endcase
    end
    if (stepEv) begin
      if ((mProg - mRem + 1) == mProg / 2) mHt = 1;
      if (last) begin
        mTc = 1;
        if (mCirc) begin mRem = mProg; mMem = mBase; mPer = mPerP; end
        else begin mRem = 0; mEn = 0; end
      end else begin
        mRem = mRem - 1;
        if (mMinc) mMem = mMem + AW'(bytes);
        if (mPinc) mPer = mPer + AW'(bytes);
      end
    end
    if (errEv) begin mErr = 1; mEn = 0; end
    mPh = nPh;
  endtask

  task automatic compareAll();
    bit expReq;
    bit mIrq;
    expReq = (mPh == 2) || (mPh == 3);
    mIrq   = (mTc && mTcIe) || (mHt && mHtIe) || (mErr && mErrIe);
    check("R2 busReq", 32'(busReq), 32'(expReq));
    if (expReq && busReq) begin
      check("R1 busWrite", 32'(busWrite), 32'(mPh == 3));
      check("R4 busAddr", 32'(busAddr), 32'((mPh == 2) ? mPer : mMem));
      check("R1 busSize", 32'(busSize), 32'(mSize));
      if (mPh == 3) check("R1 busWdata", busWdata, mData);
    end
    check("R8 irq", 32'(irq), 32'(mIrq));
    check("R3 register read", 32'(cfgRdata), 32'(mReadReg(cfgAddr)));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic step();
    bit rdAcc;
    rdAcc = 0;
    case (reqMode)
      0: periphReq = 1'b0;
      1: periphReq = 1'b1;
      default: periphReq = (cyc % 4) != 3;
    endcase
    busReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);
    #1;
    if (busReq && busReady) begin
      if (busWrite) begin memImg[int'(busAddr)] = busWdata; wrCnt++; end
      else begin lastRdAddr = busAddr; rdAcc = 1; end
    end
    modelStep();
    @(posedge clk);
    #1;
    if (rdAcc) rdCnt++;
    @(negedge clk);
    cyc++;
    compareAll();
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finishRun();
    end
  endtask

  task automatic cfgWr(input logic [2:0] a, input logic [AW-1:0] d);
    cfgWrite = 1'b1; cfgAddr = a; cfgWdata = d;
    step();
    cfgWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [AW-1:0] v);
    cfgAddr = a;
    #1;
    v = cfgRdata;
  endtask

  logic [AW-1:0] rv;
  int r0, w0;

  initial begin
    rstN = 1'b0; cfgWrite = 1'b0; cfgAddr = 3'd0; cfgWdata = '0;
    periphReq = 1'b0; busReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rdReg(3'd0, rv); check("R5 reset control", 32'(rv), 32'h0);
    rdReg(3'd3, rv); check("R3 reset count", 32'(rv), 32'h0);
    rdReg(3'd4, rv); check("R8 reset status", 32'(rv), 32'h0);
    check("R8 reset irq", 32'(irq), 32'h0);

    // R13: enabling with zero count is ignored
    cfgWr(3'd0, ctrlWord(1, 0, 1, 0, 0, 1, 0, 0));
    reqMode = 1;
    repeat (4) step();
    rdReg(3'd0, rv); check("R13 enable with zero count", 32'(rv[0]), 32'h0);
    check("R13 no bus access", 32'(rdCnt + wrCnt), 32'h0);
    reqMode = 0;

    // one-shot half-word pass of 4
    cfgWr(3'd1, 16'h0100);
    cfgWr(3'd2, 16'h0200);
    cfgWr(3'd3, 16'd4);
    r0 = rdCnt; w0 = wrCnt;
    cfgWr(3'd0, ctrlWord(1, 0, 1, 0, 1, 1, 0, 0));
    reqMode = 1;
    while (wrCnt < w0 + 4) step();
    repeat (4) step();
    for (int i = 0; i < 4; i++)
      check("R1 R4 half-word buffer slot", memImg[16'h0200 + 2 * i], val(r0 + i));
    check("R4 peripheral address fixed", 32'(lastRdAddr), 32'h0100);
    rdReg(3'd0, rv); check("R5 one-shot clears enable", 32'(rv[0]), 32'h0);
    rdReg(3'd3, rv); check("R3 count reaches zero", 32'(rv), 32'h0);
    rdReg(3'd4, rv); check("R5 R7 end and half flags", 32'(rv), 32'h3);
    check("R8 irq from end flag", 32'(irq), 32'h1);
    check("R5 no extra access", 32'(wrCnt - w0), 32'h4);

    // R9: write-1-to-clear
    cfgWr(3'd5, 16'h0000);
    rdReg(3'd4, rv); check("R9 zero write keeps flags", 32'(rv), 32'h3);
    cfgWr(3'd5, 16'h0001);
    rdReg(3'd4, rv); check("R9 clear end flag only", 32'(rv), 32'h2);
    check("R8 irq drops after clear", 32'(irq), 32'h0);
    cfgWr(3'd5, 16'h0007);

    // circular byte buffer of 5 with sparse requests and a stalling slave
    cfgWr(3'd1, 16'h0180);
    cfgWr(3'd2, 16'h0400);
    cfgWr(3'd3, 16'd5);
    r0 = rdCnt; w0 = wrCnt;
    readyMode = 1; reqMode = 2;
    cfgWr(3'd0, ctrlWord(1, 1, 1, 0, 0, 0, 1, 0));
    while (wrCnt < w0 + 12) step();
    reqMode = 0;
    repeat (4) step();
    check("R6 wrapped slot 0", memImg[16'h0400], val(r0 + 10));
    check("R6 second pass slot 2", memImg[16'h0402], val(r0 + 7));
    check("R6 second pass slot 4", memImg[16'h0404], val(r0 + 9));
    rdReg(3'd3, rv); check("R3 R6 live count after reload", 32'(rv), 32'h3);
    rdReg(3'd4, rv); check("R7 half and end flags", 32'(rv), 32'h3);
    check("R8 irq from half flag", 32'(irq), 32'h1);
    rdReg(3'd0, rv); check("R6 still enabled", 32'(rv[0]), 32'h1);

    // R10: locked configuration
    cfgWr(3'd2, 16'h0700);
    rdReg(3'd2, rv); check("R10 base locked", 32'(rv), 32'h0400);
    cfgWr(3'd3, 16'd9);
    rdReg(3'd3, rv); check("R10 count locked", 32'(rv), 32'h3);
    cfgWr(3'd0, ctrlWord(1, 0, 0, 1, 2, 1, 0, 1));
    rdReg(3'd0, rv); check("R10 control fields locked", 32'(rv), 32'(ctrlWord(1, 1, 1, 0, 0, 0, 1, 0)));

    // R12: disable in the middle of an item
    reqMode = 1;
    while (!(busReq && !busWrite)) step();
    w0 = wrCnt;
    cfgWr(3'd0, 16'h0000);
    repeat (8) step();
    check("R12 in-flight item completes", 32'(wrCnt - w0), 32'h1);
    rdReg(3'd3, rv); check("R12 count updated once", 32'(rv), 32'h2);
    r0 = rdCnt; w0 = wrCnt;
    repeat (10) step();
    check("R12 no new item after disable", 32'((rdCnt - r0) + (wrCnt - w0)), 32'h0);
    reqMode = 0;

    // R11: misaligned word buffer
    cfgWr(3'd5, 16'h0007);
    cfgWr(3'd1, 16'h0300);
    cfgWr(3'd2, 16'h0302);
    cfgWr(3'd3, 16'd2);
    r0 = rdCnt; w0 = wrCnt;
    readyMode = 0; reqMode = 1;
    cfgWr(3'd0, ctrlWord(1, 0, 1, 0, 2, 0, 0, 1));
    repeat (6) step();
    rdReg(3'd4, rv); check("R11 error flag", 32'(rv), 32'h4);
    rdReg(3'd0, rv); check("R11 enable cleared", 32'(rv[0]), 32'h0);
    check("R11 no bus access", 32'((rdCnt - r0) + (wrCnt - w0)), 32'h0);
    check("R8 irq from error", 32'(irq), 32'h1);
    cfgWr(3'd5, 16'h0004);
    check("R9 R8 error cleared", 32'(irq), 32'h0);

    // R4: peripheral increment with word items
    cfgWr(3'd1, 16'h0500);
    cfgWr(3'd2, 16'h0600);
    cfgWr(3'd3, 16'd2);
    r0 = rdCnt; w0 = wrCnt;
    readyMode = 1;
    cfgWr(3'd0, ctrlWord(1, 0, 1, 1, 2, 1, 1, 0));
    while (wrCnt < w0 + 2) step();
    repeat (4) step();
    check("R4 peripheral address advanced", 32'(lastRdAddr), 32'h0504);
    check("R4 word slot 1", memImg[16'h0604], val(r0 + 1));
    rdReg(3'd4, rv); check("R7 half flag for two items", 32'(rv), 32'h3);
    reqMode = 0;
    repeat (3) step();

    finishRun();
  end

endmodule